// File: doc/BRIEF.md
# Link alarm and statistics latch

This block watches the status lines coming from an optical receive front end and a line framer, together with per-packet event strobes, and turns them into a "since the last read" picture for a host register interface. Each alarm input is captured as a sticky bit that records whether the condition was seen at any time during the current interval. Three event counters accumulate CRC-error frames, good frames and receive FIFO errors. A loss-of-frame alarm is derived inside the block by timing how long out-of-frame persists.

A single-cycle host read strobe closes the interval. The live bits and counts move into holding registers, which the host then reads, and the live state restarts from zero in the same cycle. An event that arrives in the strobe cycle belongs to the new interval. Counters stop at their maximum value instead of wrapping. Loss of frame keeps reasserting in the live state for as long as out-of-frame stays high, so a fault that is still present shows up again after every read.

Top module: `link_stat_latch`

## Requirements
- R1: After reset, `alarm_rd` and the three count outputs read zero, and the live state is empty, so a read with no events in between returns zero.
- R2: `alarm_in` bits map as 6 receive alarm, 5 lock error, 4 power alarm, 3 signal loss, 2 clock loss, 1 out of frame, 0 pointer loss. `alarm_rd` bits map as 7 receive alarm, 6 lock error, 5 power alarm, 4 signal loss, 3 clock loss, 2 out of frame, 1 loss of frame, 0 pointer loss.
- R3: A one-cycle pulse on any alarm input sets its `alarm_rd` bit at the next read. The read after that shows the bit clear unless the input was seen again.
- R4: The receive alarm bit is recorded only in a cycle where `alarm_in[6]` is high together with `alarm_in[5]` or `alarm_in[4]`. A receive alarm on its own has no effect on `alarm_rd`.
- R5: Loss of frame is recorded when `alarm_in[1]` has been high for more than LOF_CYC = (CLK_HZ/1000)*LOF_MS consecutive cycles, that is for at least LOF_CYC+1 cycles. A shorter run records only the out-of-frame bit.
- R6: The persistence timer restarts whenever `alarm_in[1]` goes low for a cycle. Two runs of LOF_CYC cycles separated by one low cycle do not record loss of frame.
- R7: While out-of-frame persists past the limit, loss of frame is recorded again in every new interval, including an interval opened by a read strobe in the middle of the fault.
- R8: Each count output gives the number of cycles in which its strobe was high during the closed interval.
- R9: The counters saturate at 2^CNT_W-1 and do not wrap.
- R10: An alarm or strobe that is high in the same cycle as `rd_stb` is left out of that read and is reported by the following read.
- R11: The read outputs change only in the cycle after `rd_stb`, and hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_in | input | 7 | Alarm status levels, bit order in R2 |
| fcs_err_stb | input | 1 | One CRC-error frame per high cycle |
| good_pkt_stb | input | 1 | One good frame per high cycle |
| rxf_err_stb | input | 1 | One receive FIFO error per high cycle |
| rd_stb | input | 1 | Host read: closes the interval |
| alarm_rd | output | 8 | Sticky alarms of the last closed interval, bit order in R2 |
| fcs_err_rd | output | CNT_W | CRC-error count of the last closed interval |
| good_pkt_rd | output | CNT_W | Good-frame count of the last closed interval |
| rxf_err_rd | output | CNT_W | FIFO-error count of the last closed interval |

## Verification
Some properties are checked on every cycle. The snapshot never shows receive alarm without lock error or power alarm, and never shows loss of frame without out of frame. The read outputs hold between strobes. A counter at its maximum stays there until a read. The persistence timer never exceeds its limit, and loss of frame only rises after out of frame was present. Other behaviour can only be shown by the bench scenarios. These cover the exact run-length threshold for loss of frame and the timer restart on a one-cycle gap. They also cover where an event that coincides with the read strobe is placed, the per-bit mapping of each input, and the count values under sweeps of simultaneous strobes.

// File: rtl/link_stat_pkg.sv
package link_stat_pkg;
  localparam int NUM_SRC = 7;
  localparam int NUM_ALM = 8;
  localparam int NUM_CTR = 3;

  // alarm_in bit positions
  localparam int SRC_LOP = 0;
  localparam int SRC_OOF = 1;
  localparam int SRC_LOC = 2;
  localparam int SRC_LOS = 3;
  localparam int SRC_RPA = 4;
  localparam int SRC_RLE = 5;
  localparam int SRC_RAI = 6;

  // alarm_rd bit positions (fixed reporting order, receive alarm first)
  localparam int ALM_LOP = 0;
  localparam int ALM_LOF = 1;
  localparam int ALM_OOF = 2;
  localparam int ALM_LOC = 3;
  localparam int ALM_LOS = 4;
  localparam int ALM_RPA = 5;
  localparam int ALM_RLE = 6;
  localparam int ALM_RAI = 7;

  // counter slots
  localparam int CTR_FCS  = 0;
  localparam int CTR_GOOD = 1;
  localparam int CTR_RXF  = 2;
endpackage

// File: rtl/lsl_persist.sv
module lsl_persist #(
  parameter int LIMIT = 12,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          level,
  output logic          expired,
  output logic [TW-1:0] run
);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !level) run <= '0;
    else if (run != LIM) run <= run + 1'b1;
  end

  // level seen now plus LIMIT earlier cycles: strictly longer than LIMIT
  assign expired = level && (run == LIM);
endmodule

// File: rtl/lsl_sticky.sv
module lsl_sticky #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] live,
  output logic [N-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      held <= '0;
    end else if (clr) begin
      held <= live;
      live <= set;
    end else begin
      live <= live | set;
    end
  end
endmodule

// File: rtl/lsl_sat_ctr.sv
module lsl_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] live,
  output logic [W-1:0] held
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] base;

  assign base = clr ? '0 : live;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      held <= '0;
    end else begin
      if (clr) held <= live;
      live <= (inc && base != TOP) ? base + 1'b1 : base;
    end
  end
endmodule

// File: rtl/link_stat_latch.sv
module link_stat_latch
  import link_stat_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int LOF_MS = 3,
  parameter int CNT_W  = 16,
  localparam int LOF_CYC = (CLK_HZ / 1000) * LOF_MS,
  localparam int TW      = $clog2(LOF_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [6:0]       alarm_in,
  input  logic             fcs_err_stb,
  input  logic             good_pkt_stb,
  input  logic             rxf_err_stb,
  input  logic             rd_stb,
  output logic [7:0]       alarm_rd,
  output logic [CNT_W-1:0] fcs_err_rd,
  output logic [CNT_W-1:0] good_pkt_rd,
  output logic [CNT_W-1:0] rxf_err_rd
);
  logic                             lof_hit;
  logic [TW-1:0]                    lof_run;
  logic [NUM_ALM-1:0]               alm_set;
  logic [NUM_ALM-1:0]               alm_live;
  logic [NUM_CTR-1:0]               evt;
  logic [NUM_CTR-1:0][CNT_W-1:0]    cnt_live;
  logic [NUM_CTR-1:0][CNT_W-1:0]    cnt_held;

  lsl_persist #(.LIMIT(LOF_CYC)) u_lof (
    .clk     (clk),
    .rst     (rst),
    .level   (alarm_in[SRC_OOF]),
    .expired (lof_hit),
    .run     (lof_run)
  );

  always_comb begin
    alm_set          = '0;
    alm_set[ALM_RAI] = alarm_in[SRC_RAI] & (alarm_in[SRC_RLE] | alarm_in[SRC_RPA]);
    alm_set[ALM_RLE] = alarm_in[SRC_RLE];
    alm_set[ALM_RPA] = alarm_in[SRC_RPA];
    alm_set[ALM_LOS] = alarm_in[SRC_LOS];
    alm_set[ALM_LOC] = alarm_in[SRC_LOC];
    alm_set[ALM_OOF] = alarm_in[SRC_OOF];
    alm_set[ALM_LOF] = lof_hit;
    alm_set[ALM_LOP] = alarm_in[SRC_LOP];
  end

  lsl_sticky #(.N(NUM_ALM)) u_alm (
    .clk  (clk),
    .rst  (rst),
    .clr  (rd_stb),
    .set  (alm_set),
    .live (alm_live),
    .held (alarm_rd)
  );

  assign evt[CTR_FCS]  = fcs_err_stb;
  assign evt[CTR_GOOD] = good_pkt_stb;
  assign evt[CTR_RXF]  = rxf_err_stb;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    lsl_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .clr  (rd_stb),
      .inc  (evt[g]),
      .live (cnt_live[g]),
      .held (cnt_held[g])
    );
  end

  assign fcs_err_rd  = cnt_held[CTR_FCS];
  assign good_pkt_rd = cnt_held[CTR_GOOD];
  assign rxf_err_rd  = cnt_held[CTR_RXF];
endmodule

// File: rtl/lsl_chk.sv
module lsl_chk #(
  parameter int CNT_W   = 16,
  parameter int LOF_CYC = 12,
  parameter int TW      = 4,
  parameter int NCTR    = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        rd_stb,
  input logic                        oof_in,
  input logic [7:0]                  alarm_rd,
  input logic [7:0]                  alm_live,
  input logic [NCTR-1:0][CNT_W-1:0]  cnt_live,
  input logic [NCTR-1:0][CNT_W-1:0]  cnt_held,
  input logic [TW-1:0]               lof_run
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R4
  rai_pair_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_rd[7] |-> (alarm_rd[6] || alarm_rd[5]));

  // R5
  lof_with_oof_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_rd[1] |-> alarm_rd[2]);

  // R5
  lof_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alm_live[1]) |-> $past(oof_in));

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lof_run <= TW'(LOF_CYC));

  // R11
  hold_alm_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_stb) |-> $stable(alarm_rd));

  // R11
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_stb) |-> $stable(cnt_held));

  // R9
  sat_fcs_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_live[0] == TOP && !rd_stb) |=> cnt_live[0] == TOP);

  // R9
  sat_good_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_live[1] == TOP && !rd_stb) |=> cnt_live[1] == TOP);
endmodule

bind link_stat_latch lsl_chk #(
  .CNT_W   (CNT_W),
  .LOF_CYC (LOF_CYC),
  .TW      (TW),
  .NCTR    (3)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_stb   (rd_stb),
  .oof_in   (alarm_in[1]),
  .alarm_rd (alarm_rd),
  .alm_live (alm_live),
  .cnt_live (cnt_live),
  .cnt_held (cnt_held),
  .lof_run  (lof_run)
);

// File: tb/sim_link_stat_latch.sv
`timescale 1ns/1ps
module sim_link_stat_latch;
  localparam int CW = 4;
  localparam int P  = 12;   // (4000/1000)*3
  localparam int MX = (1 << CW) - 1;

  logic clk = 0;
  logic rst = 1;
  logic [6:0] alarm_in = '0;
  logic fcs = 0, good = 0, rxf = 0, rd = 0;
  logic [7:0] alarm_rd;
  logic [CW-1:0] fcs_rd, good_rd, rxf_rd;

  int n_tot = 0, n_ok = 0;
  bit done = 0;

  always #5 clk = ~clk;

  link_stat_latch #(.CLK_HZ(4000), .LOF_MS(3), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .alarm_in(alarm_in),
    .fcs_err_stb(fcs), .good_pkt_stb(good), .rxf_err_stb(rxf),
    .rd_stb(rd), .alarm_rd(alarm_rd),
    .fcs_err_rd(fcs_rd), .good_pkt_rd(good_rd), .rxf_err_rd(rxf_rd)
  );

  task automatic check(string req, int act, int exp);
    n_tot++;
    if (act == exp) n_ok++;
    else $display("FAIL %s: actual %0h expected %0h", req, act, exp);
  endtask

  task automatic do_read();
    rd = 1;
    @(negedge clk);
    rd = 0;
  endtask

  function automatic int map_bit(int i);
    case (i)
      6: return 7; 5: return 6; 4: return 5; 3: return 4;
      2: return 3; 1: return 2; default: return 0;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 alarm", alarm_rd, 0);
    check("R1 fcs", fcs_rd, 0);
    check("R1 good", good_rd, 0);
    check("R1 rxf", rxf_rd, 0);
    do_read();
    check("R1 empty live", alarm_rd, 0);

    // R2/R3 single-bit pulses (receive alarm alone covered by R4)
    for (int i = 0; i < 6; i++) begin
      alarm_in = 7'(1 << i);
      @(negedge clk);
      alarm_in = '0;
      @(negedge clk);
      do_read();
      check("R2 R3 bit map", alarm_rd, 1 << map_bit(i));
      do_read();
      check("R3 cleared", alarm_rd, 0);
    end

    // R4 receive alarm qualification
    alarm_in = 7'b100_0000;
    @(negedge clk);
    alarm_in = '0;
    do_read();
    check("R4 lone rai ignored", alarm_rd, 0);
    alarm_in = 7'b110_0000;
    @(negedge clk);
    alarm_in = 7'b101_0000;
    @(negedge clk);
    alarm_in = '0;
    do_read();
    check("R4 rai with rle/rpa", alarm_rd, 8'b1110_0000);

    // R8 counter sweep with simultaneous strobes
    for (int n = 0; n < 6; n++) begin
      for (int k = 0; k < 2 * n + 2; k++) begin
        fcs = (k < n); good = (k < n + 2); rxf = (k < 2 * n);
        @(negedge clk);
      end
      fcs = 0; good = 0; rxf = 0;
      do_read();
      check("R8 fcs", fcs_rd, n);
      check("R8 good", good_rd, n + 2);
      check("R8 rxf", rxf_rd, 2 * n);
    end

    // R9 saturation
    fcs = 1; good = 1;
    repeat (MX + 5) @(negedge clk);
    fcs = 0; good = 0;
    do_read();
    check("R9 fcs sat", fcs_rd, MX);
    check("R9 good sat", good_rd, MX);
    do_read();
    check("R9 cleared", fcs_rd, 0);

    // R10 event in the read cycle
    fcs = 1;
    repeat (2) @(negedge clk);
    alarm_in = 7'b000_1000;
    do_read();
    fcs = 0; alarm_in = '0;
    check("R10 fcs old", fcs_rd, 2);
    check("R10 alarm old", alarm_rd, 0);
    do_read();
    check("R10 fcs new", fcs_rd, 1);
    check("R10 alarm new", alarm_rd, 8'b0001_0000);

    // R11 outputs hold between reads
    rxf = 1; alarm_in = 7'b000_0001;
    repeat (3) @(negedge clk);
    rxf = 0; alarm_in = '0;
    check("R11 alarm held", alarm_rd, 8'b0001_0000);
    check("R11 rxf held", rxf_rd, 0);
    do_read();
    check("R11 rxf after read", rxf_rd, 3);

    // R5 run-length threshold sweep
    for (int len = 1; len <= P + 3; len++) begin
      alarm_in = 7'b000_0010;
      repeat (len) @(negedge clk);
      alarm_in = '0;
      @(negedge clk);
      do_read();
      check("R5 lof threshold", alarm_rd, (len > P) ? 8'b0000_0110 : 8'b0000_0100);
    end

    // R6 timer restart on a one-cycle gap
    alarm_in = 7'b000_0010;
    repeat (P) @(negedge clk);
    alarm_in = '0;
    @(negedge clk);
    alarm_in = 7'b000_0010;
    repeat (P) @(negedge clk);
    alarm_in = '0;
    @(negedge clk);
    do_read();
    check("R6 restart no lof", alarm_rd, 8'b0000_0100);

    // R7 loss of frame reappears after a read mid-fault
    alarm_in = 7'b000_0010;
    repeat (P + 3) @(negedge clk);
    do_read();
    check("R7 first read", alarm_rd, 8'b0000_0110);
    repeat (2) @(negedge clk);
    do_read();
    alarm_in = '0;
    check("R7 second read", alarm_rd, 8'b0000_0110);
    @(negedge clk);
    do_read();
    check("R7 read-cycle lof", alarm_rd, 8'b0000_0110);
    do_read();
    check("R7 cleared", alarm_rd, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tot++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_ok, n_tot);
      $finish;
    end
  end
endmodule